// File: doc/BRIEF.md
# Register Status Table with Tag-Based Renaming

This block holds the architectural register file together with a rename map. For every register the map records whether the register file already holds the current value, or which reservation station will produce it. When an instruction is dispatched, the block answers two source lookups and renames one destination. A source that is ready comes back as a value with tag zero. A source that is still waiting comes back as the nonzero tag of the station that will produce it. The destination entry is then taken over by the dispatching station's tag.

When a station completes, its tag and result are broadcast on the common result bus. Every map entry compares the broadcast tag with the tag it holds. An entry that still names the completing station takes the value into the register file and goes back to ready. An entry that has since been renamed by a newer writer ignores the broadcast. A write-after-write pair therefore never has to stall dispatch. Older consumers keep their own copies of the value, so the register file can move ahead of them safely.

Each register entry is a two-state machine, with states ST_READY and ST_PENDING. There are four transitions. ALLOC goes from ST_READY to ST_PENDING on a dispatch. RENAME goes from ST_PENDING to ST_PENDING on a dispatch, with a new tag. RETIRE goes from ST_PENDING to ST_READY on a matching broadcast. STALE goes from ST_PENDING to ST_PENDING on a broadcast whose tag does not match, and changes nothing.

Top module: `reg_status_table`

## Requirements
- R1: After reset every register reads back with tag 0 and value 0.
- R2: A source lookup of a register in ST_READY returns tag 0 and the register file value, in the same cycle (combinational).
- R3: A source lookup of a register in ST_PENDING returns its producer tag (nonzero) and value 0.
- R4: A dispatch with a nonzero tag makes the destination entry ST_PENDING with that tag from the next cycle on. This holds even when an older producer is still pending for the same register.
- R5: A broadcast whose tag equals a pending entry's tag writes the broadcast value into that register and returns the entry to tag 0 from the next cycle.
- R6: A broadcast whose tag differs from the tag held by a pending entry leaves that entry's tag and value unchanged.
- R7: When a dispatch renames a register in the same cycle that a matching broadcast completes it, the entry ends up pending on the new dispatch tag.
- R8: A source lookup whose pending tag equals the broadcast tag in the same cycle returns tag 0 and the broadcast value.
- R9: Source lookups see the mapping from before a same-cycle dispatch, so a source that is also the destination does not read its own new tag.
- R10: A broadcast with the valid bit low, or with tag 0, changes no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | Dispatch renames a destination this cycle |
| disp_dst | input | IDX_W | Destination register index |
| disp_tag | input | TAG_W | Tag of the dispatching station, nonzero |
| rd_a_idx | input | IDX_W | First source register index |
| rd_b_idx | input | IDX_W | Second source register index |
| rd_a_tag | output | TAG_W | First source producer tag, 0 when ready |
| rd_a_value | output | DATA_W | First source value, 0 while waiting |
| rd_b_tag | output | TAG_W | Second source producer tag, 0 when ready |
| rd_b_value | output | DATA_W | Second source value, 0 while waiting |
| wb_valid | input | 1 | Result broadcast valid |
| wb_tag | input | TAG_W | Tag of the completing station |
| wb_value | input | DATA_W | Broadcast result value |

## Verification
A wrong entry state shows up at the source lookup ports within one cycle of the edge that caused it, because both lookups are combinational on the entry registers. If an entry misses a RETIRE, a consumer reads back a stale nonzero tag. If an entry wrongly accepts a STALE broadcast, the register takes an old producer's value and drops the newer tag, which would release waiting consumers with the wrong operand. The bench sweeps every register against every station tag and reads all registers back after each step. This exposes a bad transition on the very next lookup.

// File: rtl/rst_pkg.sv
package rst_pkg;

    typedef enum logic {
        ST_READY   = 1'b0,
        ST_PENDING = 1'b1
    } entry_state_e;

endpackage

// File: rtl/rst_entry.sv
module rst_entry
    import rst_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int TAG_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_hit,
    input  logic [TAG_W-1:0]  alloc_tag,
    input  logic              wb_valid,
    input  logic [TAG_W-1:0]  wb_tag,
    input  logic [DATA_W-1:0] wb_value,
    output logic [TAG_W-1:0]  tag_o,
    output logic [DATA_W-1:0] value_o
);

    entry_state_e      state_q, state_d;
    logic [TAG_W-1:0]  tag_q, tag_d;
    logic [DATA_W-1:0] value_q, value_d;
    logic              wb_hit;

    assign wb_hit = wb_valid && (state_q == ST_PENDING) && (tag_q == wb_tag);

    always_comb begin
        state_d = state_q;
        tag_d   = tag_q;
        value_d = value_q;
        if (wb_hit) begin
            value_d = wb_value;
        end
        unique case (state_q)
            ST_READY: begin
                if (alloc_hit) begin
                    state_d = ST_PENDING;
                    tag_d   = alloc_tag;
                end
            end
            ST_PENDING: begin
                if (alloc_hit) begin
                    tag_d = alloc_tag;
                end else if (wb_hit) begin
                    state_d = ST_READY;
                    tag_d   = '0;
                end
            end
            default: begin
                state_d = ST_READY;
                tag_d   = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_READY;
            tag_q   <= '0;
            value_q <= '0;
        end else begin
            state_q <= state_d;
            tag_q   <= tag_d;
            value_q <= value_d;
        end
    end

    assign tag_o   = (state_q == ST_PENDING) ? tag_q : '0;
    assign value_o = value_q;

    // R3
    pending_tag_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PENDING) |-> (tag_q != '0));

    // R4
    alloc_takes_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_hit |=> ((state_q == ST_PENDING) && (tag_q == $past(alloc_tag))));

    // R5
    retire_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_hit && !alloc_hit) |=> ((state_q == ST_READY) && (value_q == $past(wb_value))));

    // R6
    stale_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && (state_q == ST_PENDING) && (tag_q != wb_tag) && !alloc_hit)
            |=> ($stable(value_q) && $stable(tag_q) && (state_q == ST_PENDING)));

endmodule

// File: rtl/rst_read_port.sv
module rst_read_port #(
    parameter int NUM_REGS = 8,
    parameter int DATA_W   = 16,
    parameter int TAG_W    = 3,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [IDX_W-1:0]                 idx,
    input  logic [NUM_REGS-1:0][TAG_W-1:0]   tags,
    input  logic [NUM_REGS-1:0][DATA_W-1:0]  values,
    input  logic                             wb_valid,
    input  logic [TAG_W-1:0]                 wb_tag,
    input  logic [DATA_W-1:0]                wb_value,
    output logic [TAG_W-1:0]                 tag_o,
    output logic [DATA_W-1:0]                value_o
);

    logic [TAG_W-1:0]  sel_tag;
    logic [DATA_W-1:0] sel_value;
    logic              bypass;

    assign sel_tag   = tags[idx];
    assign sel_value = values[idx];
    assign bypass    = wb_valid && (sel_tag != '0) && (sel_tag == wb_tag);

    always_comb begin
        if (bypass) begin
            tag_o   = '0;
            value_o = wb_value;
        end else if (sel_tag == '0) begin
            tag_o   = '0;
            value_o = sel_value;
        end else begin
            tag_o   = sel_tag;
            value_o = '0;
        end
    end

    // R3
    waiting_value_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tag_o != '0) |-> (value_o == '0));

    // R8
    bypass_forward_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && (wb_tag != '0) && (tags[idx] == wb_tag))
            |-> ((tag_o == '0) && (value_o == wb_value)));

endmodule

// File: rtl/reg_status_table.sv
module reg_status_table #(
    parameter int NUM_REGS = 8,
    parameter int DATA_W   = 16,
    parameter int TAG_W    = 3,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              disp_valid,
    input  logic [IDX_W-1:0]  disp_dst,
    input  logic [TAG_W-1:0]  disp_tag,
    input  logic [IDX_W-1:0]  rd_a_idx,
    input  logic [IDX_W-1:0]  rd_b_idx,
    output logic [TAG_W-1:0]  rd_a_tag,
    output logic [DATA_W-1:0] rd_a_value,
    output logic [TAG_W-1:0]  rd_b_tag,
    output logic [DATA_W-1:0] rd_b_value,
    input  logic              wb_valid,
    input  logic [TAG_W-1:0]  wb_tag,
    input  logic [DATA_W-1:0] wb_value
);

    logic [NUM_REGS-1:0][TAG_W-1:0]  entry_tag;
    logic [NUM_REGS-1:0][DATA_W-1:0] entry_value;
    logic [NUM_REGS-1:0]             alloc_hit;

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_entry
        assign alloc_hit[i] = disp_valid && (disp_dst == IDX_W'(i));

        rst_entry #(
            .DATA_W (DATA_W),
            .TAG_W  (TAG_W)
        ) u_entry (
            .clk       (clk),
            .rst_n     (rst_n),
            .alloc_hit (alloc_hit[i]),
            .alloc_tag (disp_tag),
            .wb_valid  (wb_valid),
            .wb_tag    (wb_tag),
            .wb_value  (wb_value),
            .tag_o     (entry_tag[i]),
            .value_o   (entry_value[i])
        );
    end

    rst_read_port #(
        .NUM_REGS (NUM_REGS),
        .DATA_W   (DATA_W),
        .TAG_W    (TAG_W)
    ) u_read_a (
        .clk      (clk),
        .rst_n    (rst_n),
        .idx      (rd_a_idx),
        .tags     (entry_tag),
        .values   (entry_value),
        .wb_valid (wb_valid),
        .wb_tag   (wb_tag),
        .wb_value (wb_value),
        .tag_o    (rd_a_tag),
        .value_o  (rd_a_value)
    );

    rst_read_port #(
        .NUM_REGS (NUM_REGS),
        .DATA_W   (DATA_W),
        .TAG_W    (TAG_W)
    ) u_read_b (
        .clk      (clk),
        .rst_n    (rst_n),
        .idx      (rd_b_idx),
        .tags     (entry_tag),
        .values   (entry_value),
        .wb_valid (wb_valid),
        .wb_tag   (wb_tag),
        .wb_value (wb_value),
        .tag_o    (rd_b_tag),
        .value_o  (rd_b_value)
    );

    // R4
    disp_tag_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid |-> (disp_tag != '0));

    // R7
    rename_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid && wb_valid && (entry_tag[disp_dst] == wb_tag) && (wb_tag != '0))
            |=> (entry_tag[$past(disp_dst)] == $past(disp_tag)));

    // R10
    quiet_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!disp_valid && (!wb_valid || (wb_tag == '0))) |=> ($stable(entry_tag) && $stable(entry_value)));

endmodule

// File: tb/reg_status_table_bench.sv
module reg_status_table_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NREG  = 8;
    localparam int DW    = 16;
    localparam int TW    = 3;
    localparam int IW    = 3;
    localparam int NTAGS = (1 << TW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          disp_valid = 1'b0;
    logic [IW-1:0] disp_dst = '0;
    logic [TW-1:0] disp_tag = '0;
    logic [IW-1:0] rd_a_idx = '0;
    logic [IW-1:0] rd_b_idx = '0;
    logic [TW-1:0] rd_a_tag, rd_b_tag;
    logic [DW-1:0] rd_a_value, rd_b_value;
    logic          wb_valid = 1'b0;
    logic [TW-1:0] wb_tag = '0;
    logic [DW-1:0] wb_value = '0;

    int checks = 0;
    int fails  = 0;
    logic [TW-1:0] m_tag [NREG];
    logic [DW-1:0] m_val [NREG];

    always #(CLK_PERIOD/2) clk = ~clk;

    reg_status_table #(.NUM_REGS(NREG), .DATA_W(DW), .TAG_W(TW)) u_reg_status_table (
        .clk(clk), .rst_n(rst_n),
        .disp_valid(disp_valid), .disp_dst(disp_dst), .disp_tag(disp_tag),
        .rd_a_idx(rd_a_idx), .rd_b_idx(rd_b_idx),
        .rd_a_tag(rd_a_tag), .rd_a_value(rd_a_value),
        .rd_b_tag(rd_b_tag), .rd_b_value(rd_b_value),
        .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_value(wb_value)
    );

    task automatic chk(input string req, input int unsigned act, input int unsigned exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // expected lookup result from requirements R2, R3, R8
    task automatic exp_read(input int r, output logic [TW-1:0] et, output logic [DW-1:0] ev);
        if (m_tag[r] != '0 && wb_valid && wb_tag == m_tag[r]) begin
            et = '0; ev = wb_value;
        end else if (m_tag[r] == '0) begin
            et = '0; ev = m_val[r];
        end else begin
            et = m_tag[r]; ev = '0;
        end
    endtask

    task automatic check_port_a(input string req);
        logic [TW-1:0] et; logic [DW-1:0] ev;
        exp_read(int'(rd_a_idx), et, ev);
        chk(req, rd_a_tag, et);
        chk(req, rd_a_value, ev);
    endtask

    task automatic check_port_b(input string req);
        logic [TW-1:0] et; logic [DW-1:0] ev;
        exp_read(int'(rd_b_idx), et, ev);
        chk(req, rd_b_tag, et);
        chk(req, rd_b_value, ev);
    endtask

    task automatic set_in(input logic dv, input int dd, input int dt,
                          input logic wv, input int wt, input int wval);
        disp_valid = dv; disp_dst = IW'(dd); disp_tag = TW'(dt);
        wb_valid = wv; wb_tag = TW'(wt); wb_value = DW'(wval);
    endtask

    // clock edge plus model update (R5 before R4/R7: dispatch tag wins)
    task automatic tick();
        @(posedge clk);
        if (wb_valid && wb_tag != '0) begin
            for (int i = 0; i < NREG; i++) begin
                if (m_tag[i] == wb_tag) begin
                    m_val[i] = wb_value;
                    m_tag[i] = '0;
                end
            end
        end
        if (disp_valid) m_tag[disp_dst] = disp_tag;
        @(negedge clk);
        set_in(1'b0, 0, 0, 1'b0, 0, 0);
    endtask

    task automatic check_all(input string req);
        for (int r = 0; r < NREG; r++) begin
            rd_a_idx = IW'(r);
            rd_b_idx = IW'(NREG - 1 - r);
            #1;
            check_port_a(req);
            check_port_b(req);
        end
    endtask

    initial begin
        for (int i = 0; i < NREG; i++) begin
            m_tag[i] = '0; m_val[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check_all("R1");

        // near-exhaustive sweep: every register against every tag
        for (int r = 0; r < NREG; r++) begin
            for (int t = 1; t <= NTAGS; t++) begin
                set_in(1'b1, r, t, 1'b0, 0, 0);
                rd_a_idx = IW'(r);
                #1;
                check_port_a("R9");
                tick();
                check_all("R3_R4");
                set_in(1'b0, 0, 0, 1'b1, t, (r * 7 + t) * 97 + 1);
                rd_b_idx = IW'(r);
                #1;
                check_port_b("R8");
                tick();
                check_all("R5_R2");
            end
        end

        // WAW: older completion ignored
        set_in(1'b1, 2, 3, 1'b0, 0, 0); tick();
        set_in(1'b1, 2, 5, 1'b0, 0, 0); tick();
        check_all("R4");
        chk("R4", m_tag[2], 5);
        set_in(1'b0, 0, 0, 1'b1, 3, 16'hAAAA); tick();
        check_all("R6");
        set_in(1'b0, 0, 0, 1'b1, 5, 16'h5555); tick();
        check_all("R5");

        // same-cycle rename and completion
        set_in(1'b1, 4, 2, 1'b0, 0, 0); tick();
        set_in(1'b1, 4, 6, 1'b1, 2, 16'h1234);
        rd_a_idx = 3'd4;
        #1;
        check_port_a("R8");
        tick();
        check_all("R7");
        chk("R7", m_tag[4], 6);
        set_in(1'b0, 0, 0, 1'b1, 6, 16'h4321); tick();
        check_all("R5");

        // quiet bus
        set_in(1'b1, 6, 7, 1'b0, 0, 0); tick();
        set_in(1'b0, 0, 0, 1'b0, 7, 16'hFFFF); tick();
        check_all("R10");
        set_in(1'b0, 0, 0, 1'b1, 0, 16'hEEEE); tick();
        check_all("R10");
        set_in(1'b0, 0, 0, 1'b1, 7, 16'h0BAD); tick();
        check_all("R5");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule